// File: doc/BRIEF.md
# Peer-Comparison Sticky Fault Detector Array

This block watches the outputs of several identical logic blocks under test that run side by side. The blocks under test are split into C sets of n. Each set is driven by its own pattern generator, and all the generators step in lockstep. On every enabled cycle, each detector takes one output position of one block slot and looks at that output from all C sets. If those C bits are not all equal, the detector latches a failure flag. No reference response and no signature are needed, because the peers serve as each other's reference. Once a detector has failed, feedback from its flag stops any further evaluation. Later patterns therefore cannot mask or alter the recorded result.

There are O × n detectors, one for each pair of output position and block slot. A synchronous clear resets every flag between test phases. A compare enable holds the detectors idle while the generators and blocks under test fill their pipelines. A registered summary flag shows whether any detector has failed.

Top module: `peer_fail_latch`

## Requirements
- R1: While rst_n is low, and on the first clock edge after it, all fail flags and any_fail are 0.
- R2: Output i (0..O-1) of block slot j (0..n-1) in set g (0..C-1) is input bit resp[(g·n + j)·O + i]. Detector k = i·n + j compares that bit across all g. If cmp_en is high at a rising edge and those C bits are not all equal, fail[k] is 1 after that edge.
- R3: When all C compared bits are equal, whether all 0 or all 1, the detector does not set its flag.
- R4: At an edge where cmp_en is low, no flag changes from 0 to 1, whatever the response bits are.
- R5: A set flag stays 1 until clr or reset, whatever later responses and enable values arrive.
- R6: clr high at a rising edge makes every flag 0 after that edge. clr wins over a mismatch that arrives at the same edge.
- R7: A mismatch seen by one detector sets only that detector's flag. The other flags keep their values.
- R8: any_fail is the OR of all fail flags delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all flags |
| cmp_en | input | 1 | Enables comparison on this cycle |
| resp | input | C·n·O | Response bits from all blocks under test |
| fail | output | O·n | Sticky per-detector failure flags, index i·n + j |
| any_fail | output | 1 | Registered OR of all flags |

## Verification
Several properties are checked on every cycle: flags hold once set (R5), nothing sets while the enable is low (R4), clear empties the array (R6), and a rise of any_fail is preceded by a set flag (R8). Other properties can only be shown by the bench's directed scenarios. These are the mapping of response bits to detectors (R2), silence for agreeing all-zero and all-one responses (R3), the isolation of each detector from its neighbours (R7), and clear taking priority over a simultaneous mismatch (R6).

// File: rtl/peer_fail_latch.sv
module peer_fail_latch #(
  parameter int C = 4,
  parameter int N = 3,
  parameter int O = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cmp_en,
  input  logic [C*N*O-1:0] resp,
  output logic [O*N-1:0]   fail,
  output logic             any_fail
);
  localparam int NDET = O * N;

  logic [NDET-1:0] mism;

  for (genvar i = 0; i < O; i++) begin : g_out
    for (genvar j = 0; j < N; j++) begin : g_slot
      logic [C-1:0] peers;
      for (genvar g = 0; g < C; g++) begin : g_set
        assign peers[g] = resp[(g*N + j)*O + i];
      end
      assign mism[i*N + j] = (|peers) & ~(&peers);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail     <= '0;
      any_fail <= 1'b0;
    end else begin
      any_fail <= |fail;
      if (clr) fail <= '0;
      else if (cmp_en) fail <= fail | mism;
    end
  end

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((fail & $past(fail)) == $past(fail)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en && !clr) |=> $stable(fail));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fail == '0));

  assert_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_fail) |-> $past(|fail));

  always_ff @(posedge clk) begin
    if (!rst_n) assert_reset_R1: assert (fail == '0 && !any_fail);
  end
endmodule

// File: tb/peer_fail_latch_bench.sv
module peer_fail_latch_bench;
  localparam int C = 4, N = 3, O = 5;
  localparam int RW = C*N*O, FW = O*N;

  logic clk = 0, rst_n = 0, clr = 0, cmp_en = 0;
  logic [RW-1:0] resp = '0;
  logic [FW-1:0] fail;
  logic any_fail;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  peer_fail_latch #(.C(C), .N(N), .O(O)) u_peer_fail_latch (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cmp_en(cmp_en),
    .resp(resp), .fail(fail), .any_fail(any_fail));

  function automatic int bitpos(int g, int j, int i);
    return (g*N + j)*O + i;
  endfunction

  task automatic chk(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [RW-1:0] r, logic en, logic c);
    resp = r; cmp_en = en; clr = c;
    @(negedge clk);
    cmp_en = 0; clr = 0;
  endtask

  task automatic t_reset;
    chk("R1 fail", fail, '0);
    chk("R1 any_fail", FW'(any_fail), '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", fail, '0);
  endtask

  task automatic t_agree;
    cyc('0, 1, 0);
    chk("R3 all zero", fail, '0);
    cyc('1, 1, 0);
    chk("R3 all one", fail, '0);
    for (int j = 0; j < N; j++) begin
      logic [RW-1:0] r = '0;
      for (int g = 0; g < C; g++) r[bitpos(g, j, 1)] = 1'b1;
      cyc(r, 1, 0);
    end
    chk("R3 agreeing slot columns", fail, '0);
  endtask

  task automatic t_single(int g, int j, int i, logic base);
    logic [RW-1:0] r = base ? '1 : '0;
    logic [FW-1:0] e = '0;
    cyc('0, 0, 1);
    r[bitpos(g, j, i)] = ~base;
    e[i*N + j] = 1'b1;
    cyc(r, 1, 0);
    chk("R2 R7 single mismatch", fail, e);
    cyc('0, 0, 0);
    chk("R8 any_fail after set", FW'(any_fail), FW'(1));
  endtask

  task automatic t_enable;
    logic [RW-1:0] r = '0;
    cyc('0, 0, 1);
    r[bitpos(2, 1, 3)] = 1'b1;
    cyc(r, 0, 0);
    cyc(r, 0, 0);
    chk("R4 disabled mismatch", fail, '0);
    chk("R4 any_fail quiet", FW'(any_fail), '0);
  endtask

  task automatic t_sticky;
    logic [RW-1:0] r = '0;
    logic [FW-1:0] e = '0;
    cyc('0, 0, 1);
    r[bitpos(0, 0, 0)] = 1'b1;
    e[0] = 1'b1;
    cyc(r, 1, 0);
    cyc('0, 1, 0);
    cyc('1, 1, 0);
    cyc(r, 0, 0);
    chk("R5 held after agreeing data", fail, e);
    r = '0;
    r[bitpos(3, 2, 4)] = 1'b1;
    e[4*N + 2] = 1'b1;
    cyc(r, 1, 0);
    chk("R7 second detector adds", fail, e);
  endtask

  task automatic t_clear;
    logic [RW-1:0] r = '0;
    logic [FW-1:0] e = '0;
    r[bitpos(1, 1, 2)] = 1'b1;
    cyc(r, 1, 0);
    chk("R6 precondition", fail[2*N+1], 1'b1);
    cyc(r, 1, 1);
    chk("R6 clear beats mismatch", fail, '0);
    cyc('0, 0, 0);
    chk("R8 any_fail lags clear", FW'(any_fail), '0);
    e[2*N+1] = 1'b1;
    cyc(r, 1, 0);
    chk("R6 detector re-arms", fail, e);
    chk("R8 any_fail one cycle late", FW'(any_fail), '0);
    cyc('0, 0, 0);
    chk("R8 any_fail follows", FW'(any_fail), FW'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_agree();
    t_single(0, 0, 0, 0);
    t_single(3, 2, 4, 0);
    t_single(1, 1, 2, 1);
    t_single(2, 2, 1, 1);
    t_enable();
    t_sticky();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule